// File: doc/BRIEF.md
# Min-max offset carrier PWM

This block turns three signed phase references into six gate signals for a three-leg voltage-source bridge. The references arrive from an external waveform source, spaced 120 degrees apart. Each time the carrier reaches a turning point, the block finds the largest and smallest of the three references. It computes a common-mode offset equal to minus half their sum and adds that offset to every phase. Each shifted phase is then clamped to the carrier span and held in a register. Centring the three references inside the carrier lets larger fundamental amplitudes stay linear.

A symmetric triangular carrier comes from an up/down counter with two states: `CAR_RISE` counts up by one per clock, and `CAR_FALL` counts down by one per clock. The counter turns from `CAR_RISE` to `CAR_FALL` at the top of the span and from `CAR_FALL` to `CAR_RISE` at the bottom. Each leg compares its held reference with the carrier, and the result is a switching demand for the upper device.

A per-leg dead-time state machine drives the gates. Its states are:
- `LEG_HI_ON`: only the upper gate is on.
- `LEG_LO_ON`: only the lower gate is on.
- `LEG_GAP_TO_LO`: both gates are off, on the way to lower.
- `LEG_GAP_TO_HI`: both gates are off, on the way to upper.

Its transitions are:
- *leave-high* (`LEG_HI_ON` to `LEG_GAP_TO_LO`) when the demand falls.
- *leave-low* (`LEG_LO_ON` to `LEG_GAP_TO_HI`) when the demand rises.
- *gap-done* (a gap state to its target) once the gap counter reaches the programmed dead time.
- *gap-reverse* (one gap state to the other, with the count restarted) when the demand flips during a gap.
- *direct* (straight between `LEG_HI_ON` and `LEG_LO_ON`) when the dead time is zero.

Top module: `mmpwm_top`

## Requirements
- R1: After reset the carrier starts at -CAR_PEAK and counts up. It changes by exactly one each clock, turns at +CAR_PEAK and at -CAR_PEAK, and repeats every 4*CAR_PEAK clocks.
- R2: The offset is -((max+min) >>> 1), where max and min are taken over the three references of one sample, and the right shift is arithmetic. The same offset is added to all three phases.
- R3: For references inside the carrier span, max+min of the three shifted outputs is 0 or 1.
- R4: Each shifted value is clamped to the range [-CAR_PEAK, +CAR_PEAK].
- R5: The shifted outputs load only on the clock edge at which the carrier equals +CAR_PEAK or -CAR_PEAK. At all other edges they hold their value.
- R6: A leg's upper demand is (shifted reference >= carrier), compared as signed values. The gate state follows the demand one clock later. With a dead time of zero, each lower gate is the inverse of its upper gate. Bit i of gate_hi and gate_lo belongs to phase A, B, C for i = 0, 1, 2.
- R7: With a dead time D > 0, after either gate of a leg turns off, both gates stay off for exactly D clocks before the opposite gate turns on.
- R8: The upper and lower gate of a leg are never on in the same cycle.
- R9: If the demand reverses during a gap, the gap restarts toward the new side. A gate whose gap never completed is never turned on.
- R10: During reset all gates are off, the carrier holds -CAR_PEAK and the shifted outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a | input | DW | Phase A reference, signed |
| ref_b | input | DW | Phase B reference, signed |
| ref_c | input | DW | Phase C reference, signed |
| dead_cyc | input | DT_W | Dead time in clocks |
| carrier | output | DW | Triangular carrier, signed |
| sh_a | output | DW | Held shifted reference, phase A |
| sh_b | output | DW | Held shifted reference, phase B |
| sh_c | output | DW | Held shifted reference, phase C |
| gate_hi | output | 3 | Upper gates, bit 0 = A |
| gate_lo | output | 3 | Lower gates, bit 0 = A |

## Verification
The bench drives references whose max+min is odd and negative. A design that halved with a logical shift, or that rounded toward zero, would leave the shifted set off-centre by one LSB or more. It drives references beyond the span, which exposes missing clamping as shifted values outside ±CAR_PEAK. It also changes references in mid half-period, where a design that loads every cycle would show a new value before the turning point. Finally, it places a reference two counts from the carrier peak with a dead time longer than the resulting notch. A leg that did not restart its gap on reversal would emit a short pulse on the wrong gate or turn both gates on together.

// File: rtl/mmpwm_pkg.sv
package mmpwm_pkg;

    localparam int unsigned PHASES = 3;

    typedef enum logic [0:0] {
        CAR_RISE = 1'b0,
        CAR_FALL = 1'b1
    } car_dir_e;

    typedef enum logic [1:0] {
        LEG_HI_ON     = 2'd0,
        LEG_GAP_TO_LO = 2'd1,
        LEG_LO_ON     = 2'd2,
        LEG_GAP_TO_HI = 2'd3
    } leg_state_e;

endpackage

// File: rtl/mmpwm_carrier.sv
module mmpwm_carrier
    import mmpwm_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CAR_PEAK = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic signed [DW-1:0] car_o,
    output logic                 turn_o
);

    localparam logic signed [DW-1:0] PK     = DW'(CAR_PEAK);
    localparam logic signed [DW-1:0] NPK    = DW'(-CAR_PEAK);
    localparam logic signed [DW-1:0] PK_M1  = DW'(CAR_PEAK - 1);
    localparam logic signed [DW-1:0] NPK_P1 = DW'(1 - CAR_PEAK);

    car_dir_e              dir_q, dir_n;
    logic signed [DW-1:0]  car_q, car_n;

    // next-state and next-count
    always_comb begin
        dir_n = dir_q;
        car_n = car_q;
        unique case (dir_q)
            CAR_RISE: begin
                car_n = car_q + DW'(1);
                if (car_q == PK_M1) dir_n = CAR_FALL;
            end
            CAR_FALL: begin
                car_n = car_q - DW'(1);
                if (car_q == NPK_P1) dir_n = CAR_RISE;
            end
            default: begin
                car_n = NPK;
                dir_n = CAR_RISE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= CAR_RISE;
            car_q <= NPK;
        end else begin
            dir_q <= dir_n;
            car_q <= car_n;
        end
    end

    // outputs
    always_comb begin
        car_o  = car_q;
        turn_o = (car_q == PK) || (car_q == NPK);
    end

    // R1
    car_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_q <= PK) && (car_q >= NPK));

    // R1
    car_rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == CAR_RISE && car_q != NPK) |=> (car_q == $past(car_q) + DW'(1)));

    // R1
    car_fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == CAR_FALL) |=> (car_q == $past(car_q) - DW'(1)));

endmodule

// File: rtl/mmpwm_offset.sv
module mmpwm_offset
    import mmpwm_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CAR_PEAK = 2000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [PHASES-1:0][DW-1:0]       ref_i,
    output logic [PHASES-1:0][DW-1:0]       sh_o
);

    localparam int EW = DW + 2;
    localparam logic signed [EW-1:0] LIM_HI = EW'(CAR_PEAK);
    localparam logic signed [EW-1:0] LIM_LO = EW'(-CAR_PEAK);

    logic signed [EW-1:0] ext   [PHASES];
    logic signed [EW-1:0] shf   [PHASES];
    logic [PHASES-1:0][DW-1:0] sat, sh_q;
    logic signed [EW-1:0] mx, mn, sum, half, offs;

    // sign-extend inputs
    for (genvar g = 0; g < PHASES; g++) begin : g_ext
        assign ext[g] = $signed({{2{ref_i[g][DW-1]}}, ref_i[g]});
    end

    // extremes and common-mode offset
    always_comb begin
        mx = ext[0];
        mn = ext[0];
        for (int i = 1; i < PHASES; i++) begin
            if (ext[i] > mx) mx = ext[i];
            if (ext[i] < mn) mn = ext[i];
        end
        sum  = mx + mn;
        half = sum >>> 1;
        offs = -half;
    end

    // shift and clamp per phase
    for (genvar g = 0; g < PHASES; g++) begin : g_shift
        always_comb begin
            shf[g] = ext[g] + offs;
            if (shf[g] > LIM_HI)      sat[g] = LIM_HI[DW-1:0];
            else if (shf[g] < LIM_LO) sat[g] = LIM_LO[DW-1:0];
            else                      sat[g] = shf[g][DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (load_i) sh_q <= sat;
    end

    assign sh_o = sh_q;

    // R5
    hold_between_turns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sh_q));

    // R4
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(sh_q[0]) <= $signed(LIM_HI[DW-1:0])) && ($signed(sh_q[0]) >= $signed(LIM_LO[DW-1:0])));

endmodule

// File: rtl/mmpwm_leg.sv
module mmpwm_leg
    import mmpwm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] sh_i,
    input  logic signed [DW-1:0] car_i,
    input  logic [DT_W-1:0]      dead_i,
    output logic                 gate_hi,
    output logic                 gate_lo
);

    leg_state_e       st_q, st_n;
    logic [DT_W-1:0]  cnt_q, cnt_n;
    logic             dem;
    logic             no_gap;

    assign dem    = (sh_i >= car_i);
    assign no_gap = (dead_i == '0);

    // next-state logic
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            LEG_HI_ON: begin
                if (!dem) begin
                    st_n  = no_gap ? LEG_LO_ON : LEG_GAP_TO_LO;
                    cnt_n = DT_W'(1);
                end
            end
            LEG_LO_ON: begin
                if (dem) begin
                    st_n  = no_gap ? LEG_HI_ON : LEG_GAP_TO_HI;
                    cnt_n = DT_W'(1);
                end
            end
            LEG_GAP_TO_LO: begin
                if (dem) begin
                    st_n  = no_gap ? LEG_HI_ON : LEG_GAP_TO_HI;
                    cnt_n = DT_W'(1);
                end else if (cnt_q >= dead_i) begin
                    st_n = LEG_LO_ON;
                end else begin
                    cnt_n = cnt_q + DT_W'(1);
                end
            end
            LEG_GAP_TO_HI: begin
                if (!dem) begin
                    st_n  = no_gap ? LEG_LO_ON : LEG_GAP_TO_LO;
                    cnt_n = DT_W'(1);
                end else if (cnt_q >= dead_i) begin
                    st_n = LEG_HI_ON;
                end else begin
                    cnt_n = cnt_q + DT_W'(1);
                end
            end
            default: begin
                st_n  = LEG_GAP_TO_LO;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LEG_GAP_TO_LO;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        gate_hi = (st_q == LEG_HI_ON);
        gate_lo = (st_q == LEG_LO_ON);
    end

    // R8
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R7
    hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dead_i) != '0 && $rose(gate_hi)) |-> $past(!gate_hi && !gate_lo));

    // R7
    lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dead_i) != '0 && $rose(gate_lo)) |-> $past(!gate_hi && !gate_lo));

endmodule

// File: rtl/mmpwm_top.sv
module mmpwm_top
    import mmpwm_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CAR_PEAK = 2000,
    parameter int DT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] ref_a,
    input  logic signed [DW-1:0] ref_b,
    input  logic signed [DW-1:0] ref_c,
    input  logic [DT_W-1:0]      dead_cyc,
    output logic signed [DW-1:0] carrier,
    output logic signed [DW-1:0] sh_a,
    output logic signed [DW-1:0] sh_b,
    output logic signed [DW-1:0] sh_c,
    output logic [2:0]           gate_hi,
    output logic [2:0]           gate_lo
);

    localparam int NPH = PHASES;

    logic signed [DW-1:0]        car;
    logic                        turn;
    logic [NPH-1:0][DW-1:0]      refs, shs;

    assign refs = {ref_c, ref_b, ref_a};

    mmpwm_carrier #(.DW(DW), .CAR_PEAK(CAR_PEAK)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .car_o  (car),
        .turn_o (turn)
    );

    mmpwm_offset #(.DW(DW), .CAR_PEAK(CAR_PEAK)) u_off (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (turn),
        .ref_i  (refs),
        .sh_o   (shs)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        mmpwm_leg #(.DW(DW), .DT_W(DT_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .sh_i    ($signed(shs[g])),
            .car_i   (car),
            .dead_i  (dead_cyc),
            .gate_hi (gate_hi[g]),
            .gate_lo (gate_lo[g])
        );
    end

    assign carrier = car;
    assign sh_a    = $signed(shs[0]);
    assign sh_b    = $signed(shs[1]);
    assign sh_c    = $signed(shs[2]);

endmodule

// File: tb/sim_mmpwm_top.sv
module sim_mmpwm_top;

    localparam int CLK_PERIOD = 10;
    localparam int PEAK       = 100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] ra = '0, rb = '0, rc = '0;
    logic [7:0]         dead = '0;
    logic signed [15:0] car, sa, sb, sc;
    logic [2:0]         ghi, glo;

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmpwm_top #(.DW(16), .CAR_PEAK(PEAK), .DT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_a(ra), .ref_b(rb), .ref_c(rc),
        .dead_cyc(dead), .carrier(car), .sh_a(sa), .sh_b(sb), .sh_c(sc),
        .gate_hi(ghi), .gate_lo(glo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int shv(input int i);
        return (i == 0) ? int'(sa) : (i == 1) ? int'(sb) : int'(sc);
    endfunction

    function automatic int exp_sh(input int a, input int b, input int c, input int sel);
        int mx, mn, h, x, v;
        mx = a; if (b > mx) mx = b; if (c > mx) mx = c;
        mn = a; if (b < mn) mn = b; if (c < mn) mn = c;
        h = (mx + mn) >>> 1;
        x = (sel == 0) ? a : (sel == 1) ? b : c;
        v = x - h;
        if (v > PEAK) v = PEAK;
        if (v < -PEAK) v = -PEAK;
        return v;
    endfunction

    task automatic set_refs(input int a, input int b, input int c);
        @(negedge clk);
        ra = 16'(a); rb = 16'(b); rc = 16'(c);
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!(car == PEAK || car == -PEAK));
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ghi == 3'b000 && glo == 3'b000, "R10 gates off in reset", int'({ghi, glo}), 0);
        chk(car == -PEAK, "R10 carrier in reset", car, -PEAK);
        chk(sa == 0 && sb == 0 && sc == 0, "R10 shifted zero in reset", sa, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_carrier();
        int prev, bad, hi, lo, t_pk, per;
        @(negedge clk);
        chk(car == -PEAK + 1, "R1 first step up", car, -PEAK + 1);
        prev = car; bad = 0; hi = car; lo = car; t_pk = -1; per = 0;
        for (int k = 1; k <= 9 * PEAK; k++) begin
            @(negedge clk);
            if (car - prev != 1 && car - prev != -1) bad++;
            if (car > hi) hi = car;
            if (car < lo) lo = car;
            if (car == PEAK) begin
                if (t_pk >= 0) per = k - t_pk;
                t_pk = k;
            end
            prev = car;
        end
        chk(bad == 0, "R1 unit steps", bad, 0);
        chk(hi == PEAK, "R1 top turning point", hi, PEAK);
        chk(lo == -PEAK, "R1 bottom turning point", lo, -PEAK);
        chk(per == 4 * PEAK, "R1 period", per, 4 * PEAK);
    endtask

    task automatic t_offset(input int a, input int b, input int c);
        set_refs(a, b, c);
        wait_load();
        chk(sa == exp_sh(a, b, c, 0), "R2 phase A", sa, exp_sh(a, b, c, 0));
        chk(sb == exp_sh(a, b, c, 1), "R2 phase B", sb, exp_sh(a, b, c, 1));
        chk(sc == exp_sh(a, b, c, 2), "R2 phase C", sc, exp_sh(a, b, c, 2));
        chk((sa - a) == (sb - b) && (sb - b) == (sc - c), "R2 common offset", sa - a, sb - b);
    endtask

    task automatic t_balance();
        int bad = 0;
        for (int k = 0; k < 8; k++) begin
            int a, b, c, mx, mn, s;
            a = ((k * 37) % 181) - 90;
            b = ((k * 53 + 17) % 171) - 85;
            c = -((a + b) / 2) + (k % 3) - 1;
            set_refs(a, b, c);
            wait_load();
            mx = sa; if (sb > mx) mx = sb; if (sc > mx) mx = sc;
            mn = sa; if (sb < mn) mn = sb; if (sc < mn) mn = sc;
            s = mx + mn;
            if (s != 0 && s != 1) begin
                bad++;
                $display("FAIL R3 balance pattern %0d actual=%0d expected=0..1", k, s);
            end
        end
        chk(bad == 0, "R3 shifted max+min within one LSB", bad, 0);
    endtask

    task automatic t_saturate();
        set_refs(300, -50, -50);
        wait_load();
        chk(sa == PEAK, "R4 clamp high A", sa, PEAK);
        chk(sb == -PEAK && sc == -PEAK, "R4 clamp low B/C", sb, -PEAK);
        set_refs(-300, 50, 50);
        wait_load();
        chk(sa == -PEAK && sb == PEAK && sc == PEAK, "R4 clamp mirrored", sa, -PEAK);
    endtask

    task automatic t_hold();
        int oa, ob, oc, bad;
        set_refs(20, -10, -4);
        wait_load();
        oa = sa; ob = sb; oc = sc; bad = 0;
        do @(negedge clk); while (car != 0);
        ra = 16'(60); rb = 16'(-60); rc = 16'(10);
        forever begin
            @(negedge clk);
            if (car == PEAK || car == -PEAK) break;
            if (sa != oa || sb != ob || sc != oc) bad++;
        end
        chk(bad == 0 && sa == oa, "R5 hold inside half-period", bad, 0);
        @(negedge clk);
        chk(sa == exp_sh(60, -60, 10, 0) && sc == exp_sh(60, -60, 10, 2),
            "R5 load at turning point", sa, exp_sh(60, -60, 10, 0));
    endtask

    task automatic t_compare();
        bit pd [3];
        int bad_hi, bad_lo;
        dead = 8'd0;
        set_refs(40, -10, -30);
        wait_load();
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) pd[i] = (shv(i) >= int'(car));
        bad_hi = 0; bad_lo = 0;
        for (int k = 0; k < 8 * PEAK; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                if (ghi[i] != pd[i]) bad_hi++;
                if (glo[i] != !ghi[i]) bad_lo++;
                pd[i] = (shv(i) >= int'(car));
            end
        end
        chk(bad_hi == 0, "R6 upper gate follows compare", bad_hi, 0);
        chk(bad_lo == 0, "R6 lower is inverse at zero dead time", bad_lo, 0);
    endtask

    task automatic t_dead(input int d);
        int len [3];
        bit seen [3];
        int bad, runs, both;
        dead = 8'(d);
        set_refs(40, -10, -30);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3; i++) begin len[i] = 0; seen[i] = 1'b0; end
        bad = 0; runs = 0; both = 0;
        for (int k = 0; k < 8 * PEAK; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                if (ghi[i] && glo[i]) both++;
                if (!ghi[i] && !glo[i]) len[i]++;
                else begin
                    if (seen[i] && len[i] > 0) begin
                        runs++;
                        if (len[i] != d) begin
                            bad++;
                            $display("FAIL R7 gap leg %0d actual=%0d expected=%0d", i, len[i], d);
                        end
                    end
                    seen[i] = 1'b1;
                    len[i] = 0;
                end
            end
        end
        chk(bad == 0 && runs >= 6, "R7 gap length", runs, 6);
        chk(both == 0, "R8 never both on", both, 0);
    endtask

    task automatic t_glitch();
        int lo_a, hi_b, off_a;
        dead = 8'd5;
        set_refs(98, -98, 0);
        wait_load();
        repeat (10) @(negedge clk);
        lo_a = 0; hi_b = 0; off_a = 0;
        for (int k = 0; k < 8 * PEAK; k++) begin
            @(negedge clk);
            if (glo[0]) lo_a++;
            if (!ghi[0]) off_a++;
            if (ghi[1]) hi_b++;
        end
        chk(lo_a == 0, "R9 lower A never on for short notch", lo_a, 0);
        chk(off_a > 0, "R9 upper A left during notch", off_a, 1);
        chk(hi_b == 0, "R9 upper B never on for short pulse", hi_b, 0);
    endtask

    initial begin
        t_reset();
        t_carrier();
        t_offset(7, 0, -2);
        t_offset(-7, 0, 2);
        t_offset(40, -10, -30);
        t_balance();
        t_saturate();
        t_hold();
        t_compare();
        t_dead(5);
        t_dead(1);
        t_glitch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

endmodule